// File: doc/BRIEF.md
# Transceiver Status and Soft-Control Byte

This block holds the one status/control byte of a pluggable optical module's monitoring page. Five module pins come in without a clock relation to the block: hardware transmit-disable, the two rate-select lines, transmit fault and receive loss-of-signal. Each pin passes through a two-flop synchronizer. A refresh tick from a parameterized divider then copies the synchronized pin states into read-only mirror bits. The tick period must stay below 100 ms of the system clock, so a pin change shows up in the byte within that bound.

Two read/write bits let the host force the transmitter off and select full bandwidth. Each soft bit is ORed with its synchronized hardware pin to drive an effective control output. When a soft feature is left out by parameter, its bit reads 0 and writes to it have no effect. Bit 0 is an active-low ready flag. It is 1 from reset and clears for good once the data-ready input has been seen.

The host reads the byte at any time on `rd_data` and writes it with a one-cycle `wr_en` strobe.

Top module: `xcvr_ctrl_status`

## Requirements
- R1: After reset, `rd_data` is 8'h01 (mirrors 0, soft bits 0, bit 0 = 1) while all pins and `data_ready` are low, and both effective outputs are 0.
- R2: Bit 6 is the soft transmit-disable bit. A write sets it to `wr_data[6]`, and the new value reads back on the cycle after the write edge.
- R3: `tx_disable_eff` is the OR of soft bit 6 and the transmit-disable pin. It follows a pin change two clock edges after the change and a write one edge after the write.
- R4: Bit 3 is the soft rate-select bit (1 = full bandwidth), written from `wr_data[3]`. `rate_sel_eff` is the OR of bit 3 and the rate-select-0 pin, with the same latencies as R3.
- R5: The mirror bits are bit 7 (transmit-disable pin), bit 5 (rate-select-1 pin), bit 4 (rate-select-0 pin), bit 2 (transmit fault) and bit 1 (loss-of-signal). A pin change appears in its mirror bit at most REFRESH_DIV+2 clock edges after the change.
- R6: Bit 0 clears three edges after `data_ready` goes high. It then stays 0 until reset, whatever `data_ready` does.
- R7: Writes have no effect on bits 7, 5, 4, 2, 1 and 0.
- R8: With SOFT_TXD_EN = 0, bit 6 reads 0 and has no effect on `tx_disable_eff`. With SOFT_RATE_EN = 0, the same holds for bit 3 and `rate_sel_eff`.
- R9: Mirror bits change only on a clock edge where the refresh tick is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Status/control byte |
| pin_tx_dis | input | 1 | Hardware transmit-disable pin, asynchronous |
| pin_rs1 | input | 1 | Rate-select-1 pin, asynchronous |
| pin_rs0 | input | 1 | Rate-select-0 pin, asynchronous |
| pin_tx_fault | input | 1 | Transmit fault pin, asynchronous |
| pin_rx_los | input | 1 | Receive loss-of-signal pin, asynchronous |
| data_ready | input | 1 | Module data-ready indication, asynchronous |
| tx_disable_eff | output | 1 | Effective transmit disable |
| rate_sel_eff | output | 1 | Effective rate select |

## Verification
Each result has its own due cycle:
- Soft-bit readback and the effective outputs after a write are due one edge after the write edge.
- The effective outputs after a pin change are due two edges after the change.
- The ready flag is due three edges after `data_ready` rises.
- A mirror bit is due REFRESH_DIV+2 edges after its pin changes, because the synchronizer adds two edges and the tick can be up to one divider period away.

The driver changes inputs on falling edges and counts exactly that many rising edges before it queues the expected byte. The monitor compares on the next falling edge, so every check lands on the last cycle a correct design may take.

// File: rtl/xcs_pkg.sv
// Package: bit layout of the status/control byte and input vector indexes.
// Assumes an 8-bit register; positions are fixed because host software decodes them.
package xcs_pkg;
    localparam int REG_W       = 8;
    localparam int B_TXD_PIN   = 7;
    localparam int B_TXD_SOFT  = 6;
    localparam int B_RS1_PIN   = 5;
    localparam int B_RS0_PIN   = 4;
    localparam int B_RATE_SOFT = 3;
    localparam int B_FAULT_PIN = 2;
    localparam int B_LOS_PIN   = 1;
    localparam int B_NRDY      = 0;

    localparam int N_IN     = 6;
    localparam int IN_TXD   = 0;
    localparam int IN_RS1   = 1;
    localparam int IN_RS0   = 2;
    localparam int IN_FAULT = 3;
    localparam int IN_LOS   = 4;
    localparam int IN_RDY   = 5;

    localparam logic [REG_W-1:0] MIRROR_MASK = 8'hB6;
endpackage

// File: rtl/xcs_sync.sv
// Module: per-bit multi-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are slow levels; no pulse capture. Resets to 0.
module xcs_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/xcs_tick.sv
// Module: free-running divider producing a one-cycle refresh tick every DIV cycles.
// Assumes DIV >= 2; DIV * clock period must stay below the 100 ms mirror bound.
module xcs_tick #(
    parameter int DIV = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count up and wrap on the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xcs_regfile.sv
// Module: status/control byte storage, soft bits, effective outputs and ready flag.
// Assumes synchronized inputs; mirrors refresh only on tick; soft bits gated by enables.
module xcs_regfile
    import xcs_pkg::*;
#(
    parameter bit SOFT_TXD_EN  = 1'b1,
    parameter bit SOFT_RATE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_txd,
    input  logic             wr_rate,
    input  logic [N_IN-1:0]  in_sync,
    output logic [REG_W-1:0] reg_q,
    output logic             txd_eff,
    output logic             rate_eff
);
    logic mir_txd, mir_rs1, mir_rs0, mir_fault, mir_los;
    logic soft_txd, soft_rate;
    logic nrdy;

    // Copy synchronized pin levels into the mirror bits on each refresh tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mir_txd   <= 1'b0;
            mir_rs1   <= 1'b0;
            mir_rs0   <= 1'b0;
            mir_fault <= 1'b0;
            mir_los   <= 1'b0;
        end else if (tick) begin
            mir_txd   <= in_sync[IN_TXD];
            mir_rs1   <= in_sync[IN_RS1];
            mir_rs0   <= in_sync[IN_RS0];
            mir_fault <= in_sync[IN_FAULT];
            mir_los   <= in_sync[IN_LOS];
        end
    end

    if (SOFT_TXD_EN) begin : g_soft_txd
        // Host-written soft transmit disable.
        always_ff @(posedge clk) begin
            if (!rst_n)     soft_txd <= 1'b0;
            else if (wr_en) soft_txd <= wr_txd;
        end
    end else begin : g_no_soft_txd
        logic unused_txd;
        assign unused_txd = wr_txd;
        assign soft_txd   = 1'b0;
    end

    if (SOFT_RATE_EN) begin : g_soft_rate
        // Host-written soft rate select.
        always_ff @(posedge clk) begin
            if (!rst_n)     soft_rate <= 1'b0;
            else if (wr_en) soft_rate <= wr_rate;
        end
    end else begin : g_no_soft_rate
        logic unused_rate;
        assign unused_rate = wr_rate;
        assign soft_rate   = 1'b0;
    end

    // Active-low ready flag: set by reset, cleared once by data_ready, never set again.
    always_ff @(posedge clk) begin
        if (!rst_n)               nrdy <= 1'b1;
        else if (in_sync[IN_RDY]) nrdy <= 1'b0;
    end

    // Combine soft bits with synchronized pins for the effective controls.
    always_comb begin
        txd_eff  = soft_txd  | in_sync[IN_TXD];
        rate_eff = soft_rate | in_sync[IN_RS0];
    end

    // Assemble the host-visible byte.
    always_comb begin
        reg_q              = '0;
        reg_q[B_TXD_PIN]   = mir_txd;
        reg_q[B_TXD_SOFT]  = soft_txd;
        reg_q[B_RS1_PIN]   = mir_rs1;
        reg_q[B_RS0_PIN]   = mir_rs0;
        reg_q[B_RATE_SOFT] = soft_rate;
        reg_q[B_FAULT_PIN] = mir_fault;
        reg_q[B_LOS_PIN]   = mir_los;
        reg_q[B_NRDY]      = nrdy;
    end
endmodule

// File: rtl/xcvr_ctrl_status.sv
// Module: top of the transceiver status/control byte.
// Assumes asynchronous pin inputs and a host that writes with a one-cycle strobe.
module xcvr_ctrl_status
    import xcs_pkg::*;
#(
    parameter int REFRESH_DIV  = 4_000_000,
    parameter int SYNC_STAGES  = 2,
    parameter bit SOFT_TXD_EN  = 1'b1,
    parameter bit SOFT_RATE_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pin_tx_dis,
    input  logic       pin_rs1,
    input  logic       pin_rs0,
    input  logic       pin_tx_fault,
    input  logic       pin_rx_los,
    input  logic       data_ready,
    output logic       tx_disable_eff,
    output logic       rate_sel_eff
);
    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] in_sync;
    logic            tick;
    logic            unused_wr;

    // Gather asynchronous inputs in package index order.
    always_comb begin
        raw_in           = '0;
        raw_in[IN_TXD]   = pin_tx_dis;
        raw_in[IN_RS1]   = pin_rs1;
        raw_in[IN_RS0]   = pin_rs0;
        raw_in[IN_FAULT] = pin_tx_fault;
        raw_in[IN_LOS]   = pin_rx_los;
        raw_in[IN_RDY]   = data_ready;
    end

    assign unused_wr = ^{wr_data[B_TXD_PIN], wr_data[B_RS1_PIN], wr_data[B_RS0_PIN],
                         wr_data[B_FAULT_PIN], wr_data[B_LOS_PIN], wr_data[B_NRDY]};

    xcs_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (in_sync)
    );

    xcs_tick #(.DIV(REFRESH_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    xcs_regfile #(.SOFT_TXD_EN(SOFT_TXD_EN), .SOFT_RATE_EN(SOFT_RATE_EN)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_txd   (wr_data[B_TXD_SOFT]),
        .wr_rate  (wr_data[B_RATE_SOFT]),
        .in_sync  (in_sync),
        .reg_q    (rd_data),
        .txd_eff  (tx_disable_eff),
        .rate_eff (rate_sel_eff)
    );
endmodule

// File: rtl/xcs_chk.sv
// Module: property checker for xcvr_ctrl_status, attached by bind below.
// Assumes the default byte layout from xcs_pkg.
module xcs_chk
    import xcs_pkg::*;
#(
    parameter bit SOFT_TXD_EN  = 1'b1,
    parameter bit SOFT_RATE_EN = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tx_disable_eff,
    input logic       rate_sel_eff
);
    // Ready flag never returns high without a reset.
    assert_nrdy_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[B_NRDY] |=> !rd_data[B_NRDY]);

    // Mirror bits hold between ticks.
    assert_mirror_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rd_data & MIRROR_MASK));

    if (SOFT_TXD_EN) begin : g_txd
        assert_soft_txd_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> rd_data[B_TXD_SOFT] == $past(wr_data[B_TXD_SOFT]));
        assert_txd_eff_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B_TXD_SOFT]) |=> tx_disable_eff);
    end else begin : g_no_txd
        assert_no_soft_txd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !rd_data[B_TXD_SOFT]);
    end

    if (SOFT_RATE_EN) begin : g_rate
        assert_soft_rate_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> rd_data[B_RATE_SOFT] == $past(wr_data[B_RATE_SOFT]));
        assert_rate_eff_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B_RATE_SOFT]) |=> rate_sel_eff);
    end else begin : g_no_rate
        assert_no_soft_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !rd_data[B_RATE_SOFT]);
    end
endmodule

bind xcvr_ctrl_status xcs_chk #(
    .SOFT_TXD_EN  (SOFT_TXD_EN),
    .SOFT_RATE_EN (SOFT_RATE_EN)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .tx_disable_eff (tx_disable_eff),
    .rate_sel_eff   (rate_sel_eff)
);

// File: tb/xcvr_ctrl_status_tb_top.sv
// Bench: scoreboard for xcvr_ctrl_status; driver queues expectations, monitor compares.
module xcvr_ctrl_status_tb_top;
    localparam int DIV  = 8;
    localparam int MWAIT = DIV + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic pin_tx_dis = 0, pin_rs1 = 0, pin_rs0 = 0, pin_tx_fault = 0, pin_rx_los = 0;
    logic data_ready = 0;
    logic [7:0] rd_a, rd_b;
    logic txd_a, rate_a, txd_b, rate_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int         req;
        bit         sel;
        bit         rd_chk;
        logic [7:0] rd;
        bit         eff_chk;
        logic [1:0] eff;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    xcvr_ctrl_status #(.REFRESH_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
        .pin_tx_dis(pin_tx_dis), .pin_rs1(pin_rs1), .pin_rs0(pin_rs0),
        .pin_tx_fault(pin_tx_fault), .pin_rx_los(pin_rx_los), .data_ready(data_ready),
        .tx_disable_eff(txd_a), .rate_sel_eff(rate_a));

    xcvr_ctrl_status #(.REFRESH_DIV(DIV), .SOFT_TXD_EN(1'b0), .SOFT_RATE_EN(1'b0)) dut_ns (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
        .pin_tx_dis(pin_tx_dis), .pin_rs1(pin_rs1), .pin_rs0(pin_rs0),
        .pin_tx_fault(pin_tx_fault), .pin_rx_los(pin_rx_los), .data_ready(data_ready),
        .tx_disable_eff(txd_b), .rate_sel_eff(rate_b));

    // Monitor: compare queued expectations on the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] rd;
            logic [1:0] ef;
            it = q.pop_front();
            rd = it.sel ? rd_b : rd_a;
            ef = it.sel ? {txd_b, rate_b} : {txd_a, rate_a};
            if (it.rd_chk) begin
                n_chk++;
                if (rd !== it.rd) begin
                    n_fail++;
                    $display("FAIL R%0d dut%0d rd_data actual %h expected %h", it.req, it.sel, rd, it.rd);
                end
            end
            if (it.eff_chk) begin
                n_chk++;
                if (ef !== it.eff) begin
                    n_fail++;
                    $display("FAIL R%0d dut%0d {txd,rate} actual %b expected %b", it.req, it.sel, ef, it.eff);
                end
            end
        end
    end

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(input int req, input bit sel, input logic [7:0] rd);
        q.push_back('{req: req, sel: sel, rd_chk: 1'b1, rd: rd, eff_chk: 1'b0, eff: 2'b00});
    endtask

    task automatic expect_eff(input int req, input bit sel, input logic [1:0] eff);
        q.push_back('{req: req, sel: sel, rd_chk: 1'b0, rd: 8'h00, eff_chk: 1'b1, eff: eff});
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        edges(1);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver.
    initial begin
        do_reset();
        edges(1);
        expect_rd(1, 0, 8'h01);                      // R1 reset byte
        expect_eff(1, 0, 2'b00);                     // R1 effective outputs
        expect_rd(1, 1, 8'h01);                      // R1 no-soft instance
        @(negedge clk);

        wr_en = 1'b1; wr_data = 8'hFF;
        edges(1);
        expect_rd(2, 0, 8'h49);                      // R2 R4 R7 soft bits set, read-only bits unchanged
        expect_eff(3, 0, 2'b11);                     // R3 R4 effective from soft bits
        expect_rd(8, 1, 8'h01);                      // R8 no-soft reads 0
        expect_eff(8, 1, 2'b00);                     // R8 no effect on outputs
        @(negedge clk);
        wr_en = 1'b0;

        host_write(8'h00);
        expect_rd(2, 0, 8'h01);                      // R2 soft cleared
        expect_eff(3, 0, 2'b00);                     // R3 outputs follow

        @(negedge clk);
        pin_tx_dis = 1'b1;
        edges(2);
        expect_eff(3, 0, 2'b10);                     // R3 pin path two edges
        expect_eff(3, 1, 2'b10);                     // R3 pin path without soft feature
        edges(MWAIT - 2);
        expect_rd(5, 0, 8'h81);                      // R5 mirror bit 7
        expect_rd(5, 1, 8'h81);
        @(negedge clk);

        @(negedge clk);
        pin_rs0 = 1'b1;
        edges(2);
        expect_eff(4, 0, 2'b11);                     // R4 rate pin path
        edges(MWAIT - 2);
        expect_rd(5, 0, 8'h91);                      // R5 mirror bit 4
        @(negedge clk);

        @(negedge clk);
        pin_tx_dis = 1'b0; pin_rs0 = 1'b0;
        pin_rs1 = 1'b1; pin_tx_fault = 1'b1; pin_rx_los = 1'b1;
        edges(MWAIT);
        expect_rd(5, 0, 8'h27);                      // R5 mirror bits 5,2,1
        expect_eff(3, 0, 2'b00);                     // R3 R4 pins released
        @(negedge clk);

        host_write(8'h08);
        expect_rd(4, 0, 8'h2F);                      // R4 soft rate readback
        expect_eff(4, 0, 2'b01);                     // R4 effective rate

        @(negedge clk);
        data_ready = 1'b1;
        edges(3);
        expect_rd(6, 0, 8'h2E);                      // R6 ready flag clears
        @(negedge clk);
        data_ready = 1'b0;
        edges(6);
        expect_rd(6, 0, 8'h2E);                      // R6 flag stays low
        @(negedge clk);

        host_write(8'h41);
        expect_rd(7, 0, 8'h66);                      // R7 bit0 write ignored, R2 bit6 set
        expect_eff(2, 0, 2'b10);                     // R2 soft disable drives output

        @(negedge clk);
        pin_rs1 = 1'b0; pin_tx_fault = 1'b0; pin_rx_los = 1'b0;
        edges(MWAIT);
        expect_rd(5, 0, 8'h40);                      // R5 mirrors cleared
        @(negedge clk);

        do_reset();
        edges(1);
        expect_rd(1, 0, 8'h01);                      // R1 second reset
        expect_eff(1, 0, 2'b00);

        edges(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule